// File: doc/BRIEF.md
# Calendar Date Counter with Leap Mode

This block keeps the calendar part of a clock: the day of the month as two BCD digits, the month number, a weekday index and a leap-mode flag. It advances once for every end-of-day pulse from the time-of-day chain. A master clear and four one-cycle pulses from already debounced buttons (day, month, weekday and leap) let the user set it. A level input tells the block that a set button is still held down.

Every register changes only on a clock edge, and each edge sees one consistent state. A count that is partway through changing can therefore never look like the end of a month. The day count starts at 01, so 00 never appears. The length of the month follows the month number and the leap flag. A month rollover that falls due while a set button is held is stored and carried out once the button is released. The leap flag drives the decimal point of the day-units digit.

Top module: `cal_date_counter`

## Requirements
- R1: After reset, and on the edge after a master-clear pulse, the outputs show day 01, month 1, weekday 0 and leap flag 0. The day outputs never show 00.
- R2: An end-of-day pulse on a day that is not the last day of the month adds one to the BCD day and leaves the month unchanged. This includes 09 to 10 and 29 to 30. Every input pulse shows on the outputs after the rising edge that samples it.
- R3: An end-of-day pulse on the last day of the month, with no set button held, loads day 01 and advances the month by one on the same edge. Month 12 goes to month 1.
- R4: February ends after day 28 when the leap flag is 0 and after day 29 when it is 1. Months 4, 6, 9 and 11 end after day 30. All other months end after day 31.
- R5: Each leap-toggle pulse inverts the leap flag. Any month step from 12 to 1, by rollover or by month-set, clears the flag, and this wins over a toggle on the same edge.
- R6: The weekday runs 0 (Monday) to 6 (Sunday). An end-of-day pulse or a weekday-set pulse advances it by one, and 6 wraps to 0.
- R7: An end-of-day pulse on the last day while the set-held level is 1 leaves the day and the month unchanged but still advances the weekday. The rollover (day 01, month plus one) happens on the first edge at which set-held is 0.
- R8: A day-set pulse advances the day by one. On the last day of the month it loads 01 and does not change the month.
- R9: A month-set pulse advances the month by one (12 wraps to 1) and keeps the day value.
- R10: When the day is beyond the length of the current month (after a month-set or a leap toggle), no set button is held and no rollover is pending, the next edge loads day 01 and keeps the month.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mclr_i | input | 1 | Master clear pulse |
| eod_i | input | 1 | End-of-day pulse from the time-of-day counter |
| day_set_i | input | 1 | Day-set button pulse |
| month_set_i | input | 1 | Month-set button pulse |
| wday_set_i | input | 1 | Weekday-set button pulse |
| leap_tgl_i | input | 1 | Leap-toggle button pulse |
| set_held_i | input | 1 | Level: a set button is still pressed |
| day_tens_o | output | 4 | Day of month, tens digit (BCD) |
| day_units_o | output | 4 | Day of month, units digit (BCD) |
| month_o | output | 4 | Month number 1 to 12 |
| wday_o | output | 3 | Weekday index 0 to 6 |
| leap_dp_o | output | 1 | Leap flag, shown on the day-units decimal point |

## Verification
A wrong month length or a wrong leap flag shows at the latest on the next end-of-day pulse that reaches the last day. The day then either reads 01 with the month one too far, or reads one day past the end of the month. A pending rollover that is lost or that fires twice shows on the first edge after set-held falls, as a month that is wrong by one. A weekday that is off by one stays off until the next clear, so the bench compares every output against a behavioural model on every cycle and runs full normal and leap years.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int unsigned MONTHS  = 12;
  localparam int unsigned MONTH_W = $clog2(MONTHS + 1);

  typedef struct packed {
    logic [3:0] tens;
    logic [3:0] units;
  } bcd_day_t;

  typedef enum logic [1:0] {
    DAY_HOLD = 2'd0,
    DAY_INC  = 2'd1,
    DAY_ONE  = 2'd2
  } day_op_e;
endpackage

// File: rtl/cal_month_len.sv
module cal_month_len
  import cal_pkg::*;
#(
  parameter int unsigned MW = MONTH_W
) (
  input  logic [MW-1:0] month_i,
  input  logic          leap_i,
  output bcd_day_t      last_day_o
);
  logic is_feb;
  logic is_short;

  assign is_feb   = (month_i == MW'(2));
  assign is_short = (month_i == MW'(4)) || (month_i == MW'(6)) ||
                    (month_i == MW'(9)) || (month_i == MW'(11));

  always_comb begin
    if (is_feb) begin
      last_day_o.tens  = 4'd2;
      last_day_o.units = leap_i ? 4'd9 : 4'd8;
    end else if (is_short) begin
      last_day_o.tens  = 4'd3;
      last_day_o.units = 4'd0;
    end else begin
      last_day_o.tens  = 4'd3;
      last_day_o.units = 4'd1;
    end
  end
endmodule

// File: rtl/cal_bcd_day.sv
module cal_bcd_day
  import cal_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  day_op_e  op_i,
  output bcd_day_t day_o
);
  bcd_day_t day_q;
  bcd_day_t day_d;
  logic     day_en;

  always_comb begin
    day_d = day_q;
    case (op_i)
      DAY_INC: begin
        if (day_q.units == 4'd9) begin
          day_d.units = 4'd0;
          day_d.tens  = day_q.tens + 4'd1;
        end else begin
          day_d.units = day_q.units + 4'd1;
        end
      end
      DAY_ONE: begin
        day_d.tens  = 4'd0;
        day_d.units = 4'd1;
      end
      default: day_d = day_q;
    endcase
  end

  assign day_en = (op_i != DAY_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      day_q.tens  <= 4'd0;
      day_q.units <= 4'd1;
    end else if (day_en) begin
      day_q <= day_d;
    end
  end

  assign day_o = day_q;
endmodule

// File: rtl/cal_wrap_counter.sv
module cal_wrap_counter #(
  parameter int unsigned LO = 0,
  parameter int unsigned HI = 6,
  parameter int unsigned W  = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;
  logic [W-1:0] q_d;
  logic         at_hi;
  logic         cnt_en;

  assign at_hi  = (q_q == W'(HI));
  assign cnt_en = clr_i | inc_i;

  always_comb begin
    if (clr_i || at_hi) q_d = W'(LO);
    else                q_d = q_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_q <= W'(LO);
    else if (cnt_en) q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/cal_date_counter.sv
module cal_date_counter
  import cal_pkg::*;
#(
  parameter int unsigned WEEKDAYS = 7,
  localparam int unsigned WDAY_W = (WEEKDAYS > 1) ? $clog2(WEEKDAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mclr_i,
  input  logic              eod_i,
  input  logic              day_set_i,
  input  logic              month_set_i,
  input  logic              wday_set_i,
  input  logic              leap_tgl_i,
  input  logic              set_held_i,
  output logic [3:0]        day_tens_o,
  output logic [3:0]        day_units_o,
  output logic [MONTH_W-1:0] month_o,
  output logic [WDAY_W-1:0] wday_o,
  output logic              leap_dp_o
);
  // reset release synchronizer
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  bcd_day_t           day;
  bcd_day_t           last_day;
  logic [MONTH_W-1:0] month_q;
  logic               leap_q;
  logic               leap_d;
  logic               leap_en;
  logic               pend_q;
  logic               pend_d;
  logic               pend_en;
  logic               roll;
  logic               month_inc;
  logic               month_wrap;
  logic               wday_inc;
  logic               at_end;
  logic               past_end;
  day_op_e            day_op;

  cal_month_len #(.MW(MONTH_W)) u_len (
    .month_i    (month_q),
    .leap_i     (leap_q),
    .last_day_o (last_day)
  );

  assign at_end   = ({day.tens, day.units} == {last_day.tens, last_day.units});
  assign past_end = ({day.tens, day.units} >  {last_day.tens, last_day.units});

  // day / rollover control
  always_comb begin
    day_op = DAY_HOLD;
    roll   = 1'b0;
    pend_d = pend_q;
    if (mclr_i) begin
      day_op = DAY_ONE;
      pend_d = 1'b0;
    end else if (pend_q && !set_held_i) begin
      roll   = 1'b1;
      day_op = DAY_ONE;
      pend_d = 1'b0;
    end else if (eod_i && at_end) begin
      if (set_held_i) begin
        pend_d = 1'b1;
      end else begin
        roll   = 1'b1;
        day_op = DAY_ONE;
      end
    end else if (eod_i || day_set_i) begin
      day_op = at_end ? DAY_ONE : DAY_INC;
    end else if (past_end && !set_held_i) begin
      day_op = DAY_ONE;
    end
  end

  assign pend_en = mclr_i | roll | (eod_i & at_end & set_held_i);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  cal_bcd_day u_day (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .op_i  (day_op),
    .day_o (day)
  );

  // month
  assign month_inc  = ~mclr_i & (roll | month_set_i);
  assign month_wrap = month_inc & (month_q == MONTH_W'(MONTHS));

  cal_wrap_counter #(.LO(1), .HI(MONTHS), .W(MONTH_W)) u_month (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr_i (mclr_i),
    .inc_i (month_inc),
    .q_o   (month_q)
  );

  // leap flag
  always_comb begin
    if (mclr_i || month_wrap) leap_d = 1'b0;
    else                      leap_d = ~leap_q;
  end

  assign leap_en = mclr_i | month_wrap | leap_tgl_i;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  leap_q <= 1'b0;
    else if (leap_en) leap_q <= leap_d;
  end

  // weekday
  assign wday_inc = ~mclr_i & (eod_i | wday_set_i);

  cal_wrap_counter #(.LO(0), .HI(WEEKDAYS - 1), .W(WDAY_W)) u_wday (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr_i (mclr_i),
    .inc_i (wday_inc),
    .q_o   (wday_o)
  );

  assign day_tens_o  = day.tens;
  assign day_units_o = day.units;
  assign month_o     = month_q;
  assign leap_dp_o   = leap_q;
endmodule

// File: rtl/cal_date_counter_chk.sv
module cal_date_counter_chk #(
  parameter int unsigned WEEKDAYS = 7,
  parameter int unsigned MW       = 4,
  parameter int unsigned WW       = 3
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic          mclr_i,
  input logic          eod_i,
  input logic          day_set_i,
  input logic          month_set_i,
  input logic          leap_tgl_i,
  input logic          set_held_i,
  input logic [3:0]    day_tens_o,
  input logic [3:0]    day_units_o,
  input logic [MW-1:0] month_o,
  input logic [WW-1:0] wday_o,
  input logic          leap_dp_o,
  input logic          pend_q,
  input logic [7:0]    last_day
);
  logic [7:0] day;
  assign day = {day_tens_o, day_units_o};

  p_day_nonzero_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    day != 8'h00);

  p_clear_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mclr_i |=> (day == 8'h01 && month_o == MW'(1) && wday_o == '0 && !leap_dp_o));

  p_bcd_digits_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    day_units_o <= 4'd9 && day_tens_o <= 4'd3);

  p_rollover_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!mclr_i && eod_i && day == last_day && !set_held_i && !pend_q)
    |=> (day == 8'h01 &&
         month_o == (($past(month_o) == MW'(12)) ? MW'(1) : MW'($past(month_o) + 1'b1))));

  p_leap_flip_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!mclr_i && leap_tgl_i && month_o != MW'(12)) |=> (leap_dp_o != $past(leap_dp_o)));

  p_wday_range_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wday_o < WW'(WEEKDAYS));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!mclr_i && set_held_i && eod_i && day == last_day && !month_set_i)
    |=> (day == $past(day) && $stable(month_o) && pend_q));

  p_month_range_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    month_o >= MW'(1) && month_o <= MW'(12));

  p_clamp_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!mclr_i && !set_held_i && !pend_q && !eod_i && !day_set_i && !month_set_i &&
     day > last_day) |=> (day == 8'h01 && $stable(month_o)));
endmodule

bind cal_date_counter cal_date_counter_chk #(
  .WEEKDAYS (WEEKDAYS),
  .MW       (MONTH_W),
  .WW       (WDAY_W)
) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .mclr_i      (mclr_i),
  .eod_i       (eod_i),
  .day_set_i   (day_set_i),
  .month_set_i (month_set_i),
  .leap_tgl_i  (leap_tgl_i),
  .set_held_i  (set_held_i),
  .day_tens_o  (day_tens_o),
  .day_units_o (day_units_o),
  .month_o     (month_o),
  .wday_o      (wday_o),
  .leap_dp_o   (leap_dp_o),
  .pend_q      (pend_q),
  .last_day    ({last_day.tens, last_day.units})
);

// File: tb/cal_date_counter_tb.sv
module cal_date_counter_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       mclr_i, eod_i, day_set_i, month_set_i, wday_set_i, leap_tgl_i, set_held_i;
  logic [3:0] day_tens_o, day_units_o, month_o;
  logic [2:0] wday_o;
  logic       leap_dp_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // reference model state
  int md, mm, mw, ml, mp;

  always #4 clk = ~clk;

  cal_date_counter u_dut (
    .clk(clk), .rst_n(rst_n), .mclr_i(mclr_i), .eod_i(eod_i),
    .day_set_i(day_set_i), .month_set_i(month_set_i), .wday_set_i(wday_set_i),
    .leap_tgl_i(leap_tgl_i), .set_held_i(set_held_i),
    .day_tens_o(day_tens_o), .day_units_o(day_units_o), .month_o(month_o),
    .wday_o(wday_o), .leap_dp_o(leap_dp_o)
  );

  function automatic int mlen(int m, int l);
    if (m == 2) return (l != 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic int dut_day();
    return int'(day_tens_o) * 10 + int'(day_units_o);
  endfunction

  task automatic check(string tag, int d, int m, int w, int l);
    n_checks++;
    if (day_units_o > 4'd9 || dut_day() != d || int'(month_o) != m ||
        int'(wday_o) != w || int'(leap_dp_o) != l) begin
      n_fail++;
      $display("FAIL %s: got day=%0d%0d mon=%0d wd=%0d leap=%0d exp day=%0d mon=%0d wd=%0d leap=%0d",
               tag, day_tens_o, day_units_o, month_o, wday_o, leap_dp_o, d, m, w, l);
    end
  endtask

  // apply one cycle of inputs, advance the model, compare after the edge
  task automatic drive(string tag, bit e, bit ds, bit ms, bit ws, bit lt, bit mc, bit h);
    int nd, nm, nw, nl, np;
    bit roll;
    eod_i = e; day_set_i = ds; month_set_i = ms; wday_set_i = ws;
    leap_tgl_i = lt; mclr_i = mc; set_held_i = h;
    nd = md; nm = mm; nw = mw; nl = ml; np = mp; roll = 0;
    if (mc) begin
      nd = 1; nm = 1; nw = 0; nl = 0; np = 0;
    end else begin
      if (e || ws) nw = (mw + 1) % 7;
      if (mp != 0 && !h) begin
        roll = 1; nd = 1; np = 0;
      end else if (e && md == mlen(mm, ml)) begin
        if (h) np = 1;
        else begin roll = 1; nd = 1; end
      end else if (e || ds) begin
        nd = (md == mlen(mm, ml)) ? 1 : md + 1;
      end else if (!h && md > mlen(mm, ml)) begin
        nd = 1;
      end
      if (roll || ms) nm = (mm == 12) ? 1 : mm + 1;
      if ((roll || ms) && mm == 12) nl = 0;
      else if (lt) nl = (ml != 0) ? 0 : 1;
    end
    md = nd; mm = nm; mw = nw; ml = nl; mp = np;
    @(negedge clk);
    check(tag, md, mm, mw, ml);
  endtask

  task automatic eods(string tag, int n);
    for (int i = 0; i < n; i++) drive(tag, 1, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got no finish, exp finish");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int w0;
    rst_n = 0;
    mclr_i = 0; eod_i = 0; day_set_i = 0; month_set_i = 0;
    wday_set_i = 0; leap_tgl_i = 0; set_held_i = 0;
    md = 1; mm = 1; mw = 0; ml = 0; mp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 reset", 1, 1, 0, 0);

    // R2: mid-month steps including 09->10 and 29->30
    eods("R2", 28);
    check("R2 day29", 29, 1, 28 % 7, 0);
    eods("R2", 1);
    check("R2 day30", 30, 1, 29 % 7, 0);
    // R3: end of January
    eods("R3", 1);
    eods("R3", 1);
    check("R3 jan-feb", 1, 2, 31 % 7, 0);
    // R4: February without leap
    eods("R4", 27);
    check("R4 feb28", 28, 2, 58 % 7, 0);
    eods("R4", 1);
    check("R4 mar1", 1, 3, 59 % 7, 0);
    // rest of the year, all month lengths
    while (!(mm == 12 && md == 31)) drive("R4", 1, 0, 0, 0, 0, 0, 0);
    eods("R3", 1);
    check("R3 dec-jan R6 wday", 1, 1, 365 % 7, 0);

    // R5 / R4: leap year
    drive("R5", 0, 0, 0, 0, 1, 0, 0);
    check("R5 toggle", 1, 1, 1, 1);
    eods("R4", 59);
    check("R4 feb29", 29, 2, (1 + 59) % 7, 1);
    eods("R4", 1);
    check("R4 leap mar1", 1, 3, (1 + 60) % 7, 1);
    while (!(mm == 12 && md == 31)) drive("R4", 1, 0, 0, 0, 0, 0, 0);
    check("R5 leap kept", 31, 12, mw, 1);
    eods("R5", 1);
    check("R5 leap cleared", 1, 1, mw, 0);

    // R7: rollover held off while a set button is held
    eods("R7", 30);
    w0 = mw;
    drive("R7", 1, 0, 0, 0, 0, 0, 1);
    check("R7 held", 31, 1, (w0 + 1) % 7, 0);
    drive("R7", 0, 0, 0, 0, 0, 0, 1);
    check("R7 still held", 31, 1, (w0 + 1) % 7, 0);
    drive("R7", 0, 0, 0, 0, 0, 0, 0);
    check("R7 released", 1, 2, (w0 + 1) % 7, 0);

    // R8: day-set wraps within month
    for (int i = 0; i < 27; i++) drive("R8", 0, 1, 0, 0, 0, 0, 0);
    check("R8 feb28", 28, 2, mw, 0);
    drive("R8", 0, 1, 0, 0, 0, 0, 0);
    check("R8 wrap", 1, 2, mw, 0);

    // R9 / R10: month-set keeps day, clamp after release
    drive("R9", 0, 0, 1, 0, 0, 0, 0);
    check("R9 month step", 1, 3, mw, 0);
    for (int i = 0; i < 30; i++) drive("R8", 0, 1, 0, 0, 0, 0, 0);
    check("R8 mar31", 31, 3, mw, 0);
    drive("R9", 0, 0, 1, 0, 0, 0, 1);
    check("R9 apr31 held", 31, 4, mw, 0);
    drive("R10", 0, 0, 0, 0, 0, 0, 0);
    check("R10 clamp", 1, 4, mw, 0);

    // R5: wrap by month-set wins over a toggle on the same edge
    for (int i = 0; i < 8; i++) drive("R9", 0, 0, 1, 0, 0, 0, 0);
    drive("R5", 0, 0, 0, 0, 1, 0, 0);
    check("R5 dec leap", 1, 12, mw, 1);
    drive("R5", 0, 0, 1, 0, 1, 0, 0);
    check("R5 wrap wins", 1, 1, mw, 0);

    // R6: weekday set
    w0 = mw;
    drive("R6", 0, 0, 0, 1, 0, 0, 0);
    check("R6 step", 1, 1, (w0 + 1) % 7, 0);
    for (int i = 0; i < 6; i++) drive("R6", 0, 0, 0, 1, 0, 0, 0);
    check("R6 full turn", 1, 1, w0, 0);

    // R1: master clear mid-state
    eods("R1", 40);
    drive("R5", 0, 0, 0, 0, 1, 0, 0);
    drive("R1", 0, 0, 0, 0, 0, 1, 0);
    check("R1 mclr", 1, 1, 0, 0);
    drive("R1", 0, 0, 0, 0, 0, 0, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule